// File: doc/BRIEF.md
# Token-ring running median filter

This block computes a running median over the most recent N samples of a stream, where N is odd. It keeps the window in N fixed storage cells. Each cell holds one sample, that sample's rank within the window, and a token bit. Samples are never moved or re-sorted. Each accepted sample overwrites the cell that holds the token, which is always the cell with the oldest sample. The token then passes to the next cell in the ring. Every other cell adjusts its own rank in place. A second register stage selects the sample whose rank is the middle rank and presents it as the output.

It is intended for impulse-noise removal on a one-dimensional stream, such as audio or one scan line. The producer drives `in_valid` with each sample. The consumer reads `out_data` one cycle after each accepted sample. Until N samples have arrived, the positions that are still empty behave as samples of value zero.

Top module: `tok_median`

## Requirements
- R1: While `rst_n` is low and after its release, `out_data` is 0 and `out_valid` is 0 until a sample has been accepted. Reset clears every stored sample and rank to 0 and places the token in the last cell (index N-1).
- R2: An accepted sample is written into the one cell that holds the token. The token then advances from index i to index i+1, and from index N-1 back to index 0, so exactly one cell holds it at all times.
- R3: While `in_valid` is low, the stored samples, ranks and token do not change. `out_data` does not change in the cycle that follows.
- R4: The cell that receives a sample takes the rank K+1, where K is the number of other cells whose stored value is less than or equal to the new sample.
- R5: With Pt the old rank of the token cell, each other cell changes its rank as follows. It decrements when its rank exceeds Pt and its value is less than or equal to the new sample. It increments when its rank is below Pt and its value exceeds the new sample. In all other cases it keeps its rank.
- R6: One clock after a sample is accepted, `out_data` equals the median of the last N accepted samples, meaning the element at ascending index (N-1)/2.
- R7: Before N samples have been accepted, the empty positions count as value 0 in the median.
- R8: `out_valid` goes high together with the median that includes the N-th accepted sample and stays high until reset.
- R9: Repeated and equal sample values give the exact median. The ranks of a full window form a permutation of 1..N.
- R10: With `in_valid` held high, a new median appears on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept `in_data` on this edge |
| in_data | input | W | Incoming sample, unsigned |
| out_valid | output | 1 | Window has been filled once |
| out_data | output | W | Registered median |

## Verification
The assertions assume that `in_valid` and `in_data` are driven to known values on every clock after reset. They also assume that reset is applied before the first sample, so that the ranks start from the all-zero state that the update rules depend on. The bench drives its inputs only on falling edges. It holds `in_valid` low throughout reset, and it mixes long back-to-back bursts with random idle gaps. Runs of repeated values and the extremes 0 and 255 are included, so that tie handling and the fill phase are exercised for window sizes 5 and 9.

// File: rtl/tok_median.sv
module tok_median #(
  parameter int N = 5,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int PW  = $clog2(N + 1);
  localparam int MID = (N + 1) / 2;

  logic [N-1:0][W-1:0]  val;
  logic [N-1:0][PW-1:0] rank;
  logic [N-1:0]         tok;
  logic [N-1:0]         le;
  logic [PW-1:0]        pt;
  logic [PW-1:0]        kcnt;
  logic [W-1:0]         pick;
  logic [PW-1:0]        seen;
  logic                 upd_q;

  always_comb begin
    pt   = '0;
    kcnt = '0;
    pick = '0;
    for (int i = 0; i < N; i++) begin
      le[i] = val[i] <= in_data;
      if (tok[i]) pt = pt | rank[i];
      if (le[i] && !tok[i]) kcnt = kcnt + 1'b1;
      if (rank[i] == PW'(MID)) pick = pick | val[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val  <= '0;
      rank <= '0;
      tok  <= N'(1) << (N - 1);
    end else if (in_valid) begin
      for (int i = 0; i < N; i++) begin
        if (tok[i]) begin
          val[i]  <= in_data;
          rank[i] <= kcnt + 1'b1;
        end else if (rank[i] > pt && le[i]) begin
          rank[i] <= rank[i] - 1'b1;
        end else if (rank[i] < pt && !le[i]) begin
          rank[i] <= rank[i] + 1'b1;
        end
      end
      tok <= {tok[N-2:0], tok[N-1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_q     <= 1'b0;
      seen      <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      upd_q <= in_valid;
      if (in_valid && seen != PW'(N)) seen <= seen + 1'b1;
      if (upd_q) begin
        out_data  <= pick;
        out_valid <= seen == PW'(N);
      end
    end
  end
endmodule

// File: rtl/tok_median_chk.sv
module tok_median_chk #(
  parameter int N  = 5,
  parameter int W  = 8,
  parameter int PW = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic [W-1:0]         out_data,
  input logic [N-1:0]         tok,
  input logic [N-1:0][PW-1:0] rank
);
  logic [N-1:0] is_mid;
  logic [N-1:0] is_zero;
  always_comb
    for (int i = 0; i < N; i++) begin
      is_mid[i]  = rank[i] == PW'((N + 1) / 2);
      is_zero[i] = rank[i] == '0;
    end

  assert_tok_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tok) == 1);
  assert_tok_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> tok == {$past(tok[N-2:0]), $past(tok[N-1])});
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(tok) && $stable(rank));
  assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 $stable(out_data));
  assert_valid_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid);
  assert_perm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(is_mid) == 1 && is_zero == '0);
endmodule

bind tok_median tok_median_chk #(.N(N), .W(W), .PW(PW)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_data(out_data), .tok(tok), .rank(rank)
);

// File: tb/test_tok_median.sv
`timescale 1ns/1ps
module test_tok_median;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, vin;
  logic [7:0] din;
  logic       ov5, ov9;
  logic [7:0] y5, y9;

  tok_median #(.N(5), .W(8)) i_tok_median (
    .clk(clk), .rst_n(rst_n), .in_valid(vin), .in_data(din),
    .out_valid(ov5), .out_data(y5));
  tok_median #(.N(9), .W(8)) i_tok_median_n9 (
    .clk(clk), .rst_n(rst_n), .in_valid(vin), .in_data(din),
    .out_valid(ov9), .out_data(y9));

  int checks = 0, fails = 0, cnt = 0;
  int w5[$], w9[$];
  bit pend = 0;
  int e5 = 0, e9 = 0;
  bit eo5 = 0, eo9 = 0;
  string tag = "R1";
  logic [7:0] last = 0;

  function automatic int med(input int q[$], input int n);
    int a[$];
    a = q;
    while (a.size() < n) a.push_back(0);
    a.sort();
    return a[(n - 1) / 2];
  endfunction

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [7:0] d);
    @(negedge clk);
    chk({tag, " N5 median (R6, R2 R4 R5 rank upkeep)"}, y5, e5);
    chk({tag, " N9 median (R6, R2 R4 R5 rank upkeep)"}, y9, e9);
    chk({tag, " N5 out_valid R8"}, ov5, eo5);
    chk({tag, " N9 out_valid R8"}, ov9, eo9);
    if (pend) begin
      e5 = med(w5, 5); e9 = med(w9, 9);
      eo5 = cnt >= 5;  eo9 = cnt >= 9;
    end
    vin = v; din = d;
    if (v) begin
      w5.push_back(d); if (w5.size() > 5) void'(w5.pop_front());
      w9.push_back(d); if (w9.size() > 9) void'(w9.pop_front());
      cnt++;
      last = d;
    end
    pend = v;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 0; vin = 0; din = 0;
    repeat (4) @(negedge clk);
    chk("R1 reset out_data", y5, 0);
    chk("R1 reset out_data N9", y9, 0);
    chk("R1 reset out_valid", ov5, 0);
    rst_n = 1;
    tag = "R7 fill";
    for (int i = 0; i < 12; i++) step(1'b1, 8'($urandom_range(1, 255)));
    tag = "R10 burst";
    for (int i = 0; i < 1000; i++) step(1'b1, 8'($urandom));
    tag = "R9 ties";
    for (int i = 0; i < 500; i++)
      step(1'b1, ($urandom % 3 == 0) ? last : 8'(($urandom % 4) * 85));
    tag = "R3 gaps";
    for (int i = 0; i < 500; i++) step(($urandom % 2) == 1, 8'($urandom));
    tag = "R9 R3 ties with gaps";
    for (int i = 0; i < 400; i++) step(($urandom % 3) != 0, 8'($urandom % 3));
    step(1'b0, 8'd0);
    step(1'b0, 8'd0);
    summary();
  end
endmodule